// File: doc/BRIEF.md
# Low-Voltage Flag Controller

This block sits between two digital comparator outputs and the status logic that software reads. One comparator reports that the supply has dropped under the detect trip point. The other reports that it has dropped under a separately chosen warning trip point. Each indication is resynchronised to the system clock and then held in a sticky flag. Software clears a flag by pulsing that flag's acknowledge input. The clear takes effect only if the supply is back above that flag's trip point. Otherwise the flag stays set.

A 3-bit power-mode code picks the regulator mode. The two very-low-power codes put the regulator into low-power mode. Every other code means full performance. While the regulator is in low-power mode, the whole detect system is off: both flags are held clear and no reset request is made. When the reset-enable input is high, the block raises a low-voltage reset request for as long as the synchronised detect indication is asserted.

Top module: `lvd_flag_ctrl`

## Requirements
- R1: `pwr_mode` codes 4 and 5 select low-power regulator mode (`reg_lowpwr`=1). Codes 0, 1, 2 and 3 select full-performance mode (`reg_lowpwr`=0), and so do the unused codes 6 and 7. The decode is combinational.
- R2: Each comparator input passes through a two-flop synchroniser. A flag first shows a change of its raw input after the third rising clock edge. The reset request first shows it after the second edge.
- R3: In full-performance mode, `det_flag` becomes 1 on the edge after the synchronised detect input is 1. It then stays 1 until a valid acknowledge clears it.
- R4: A 1 on `det_ack` clears `det_flag` only when the synchronised detect input is 0. If the input is 1 in that cycle, setting wins and the flag stays 1. A 0 on `det_ack` has no effect.
- R5: In full-performance mode, `warn_flag` becomes 1 on the edge after the synchronised warning input is 1. It then stays 1 until a valid acknowledge clears it.
- R6: A 1 on `warn_ack` clears `warn_flag` only when the synchronised warning input is 0. If the input is 1 in that cycle, setting wins. A 0 on `warn_ack` has no effect.
- R7: While `reg_lowpwr` is 1, both flags are cleared on the next edge and held at 0. `lv_rst_req` is 0 throughout.
- R8: `lv_rst_req` is 1 exactly when `rst_req_en` is 1, the synchronised detect input is 1 and the regulator is in full-performance mode.
- R9: Reset (`rst_n`=0) clears both flags and the synchronisers. After release, each flag follows the supply level: it sets if its input is below threshold and stays 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_mode | input | 3 | Chip power-mode code |
| below_det_raw | input | 1 | Asynchronous comparator output: supply under detect point |
| below_warn_raw | input | 1 | Asynchronous comparator output: supply under warning point |
| det_ack | input | 1 | Write-one acknowledge for the detect flag |
| warn_ack | input | 1 | Write-one acknowledge for the warning flag |
| rst_req_en | input | 1 | Enables the low-voltage reset request |
| det_flag | output | 1 | Sticky detect flag |
| warn_flag | output | 1 | Sticky warning flag |
| lv_rst_req | output | 1 | Low-voltage reset request |
| reg_lowpwr | output | 1 | 1 when the regulator is in low-power mode |

## Verification
The assertions check these rules on every cycle:
- Low-power mode clears both flags and blocks the reset request.
- A request never appears without its enable.
- A flag with no acknowledge holds its value.
- A reset request is always followed by a set detect flag.

The bench scenarios cover the rest. They show the synchroniser latency in exact cycles and the decode of every mode code, including unused codes. They show that an acknowledge is refused while the supply is still low, and that flags return to the supply level after reset.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    PM_HSRUN = 3'd0,
    PM_RUN   = 3'd1,
    PM_STOP1 = 3'd2,
    PM_STOP2 = 3'd3,
    PM_VLPR  = 3'd4,
    PM_VLPS  = 3'd5
  } pwr_mode_e;

  typedef enum logic {
    REG_FULL = 1'b0,
    REG_LOW  = 1'b1
  } reg_mode_e;

  // Flag slot indices inside the per-channel vectors
  localparam int CH_DET  = 0;
  localparam int CH_WARN = 1;
  localparam int NUM_CH  = 2;
endpackage

// File: rtl/lvd_sync.sv
module lvd_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/lvd_mode_decode.sv
module lvd_mode_decode
  import lvd_pkg::*;
(
  input  logic [MODE_W-1:0] mode_code,
  output reg_mode_e         reg_mode
);
  always_comb begin
    case (mode_code)
      PM_VLPR, PM_VLPS: reg_mode = REG_LOW;
      default:          reg_mode = REG_FULL;
    endcase
  end
endmodule

// File: rtl/lvd_sticky_flag.sv
module lvd_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic disable_i,
  input  logic below_i,
  input  logic ack_i,
  output logic flag_o
);
  logic flag_nxt;

  always_comb begin
    flag_nxt = flag_o;
    if (disable_i)      flag_nxt = 1'b0;
    else if (below_i)   flag_nxt = 1'b1;
    else if (ack_i)     flag_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= flag_nxt;
  end
endmodule

// File: rtl/lvd_flag_ctrl.sv
module lvd_flag_ctrl
  import lvd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] pwr_mode,
  input  logic              below_det_raw,
  input  logic              below_warn_raw,
  input  logic              det_ack,
  input  logic              warn_ack,
  input  logic              rst_req_en,
  output logic              det_flag,
  output logic              warn_flag,
  output logic              lv_rst_req,
  output logic              reg_lowpwr
);
  logic [NUM_CH-1:0] raw_vec, sync_vec, ack_vec, flag_vec;
  reg_mode_e         reg_mode;
  logic              lp_active;

  assign raw_vec[CH_DET]  = below_det_raw;
  assign raw_vec[CH_WARN] = below_warn_raw;
  assign ack_vec[CH_DET]  = det_ack;
  assign ack_vec[CH_WARN] = warn_ack;

  lvd_mode_decode u_mode (
    .mode_code (pwr_mode),
    .reg_mode  (reg_mode)
  );
  assign lp_active = (reg_mode == REG_LOW);

  lvd_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (raw_vec),
    .dout  (sync_vec)
  );

  genvar ch;
  generate
    for (ch = 0; ch < NUM_CH; ch++) begin : g_flag
      lvd_sticky_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .disable_i (lp_active),
        .below_i   (sync_vec[ch]),
        .ack_i     (ack_vec[ch]),
        .flag_o    (flag_vec[ch])
      );
    end
  endgenerate

  assign det_flag   = flag_vec[CH_DET];
  assign warn_flag  = flag_vec[CH_WARN];
  assign lv_rst_req = rst_req_en & sync_vec[CH_DET] & ~lp_active;
  assign reg_lowpwr = lp_active;
endmodule

// File: rtl/lvd_flag_ctrl_chk.sv
module lvd_flag_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic det_ack,
  input logic warn_ack,
  input logic rst_req_en,
  input logic det_flag,
  input logic warn_flag,
  input logic lv_rst_req,
  input logic reg_lowpwr
);
  AST_LP_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_lowpwr |=> (!det_flag && !warn_flag)); // R7
  AST_LP_NO_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    reg_lowpwr |-> !lv_rst_req); // R7
  AST_REQUEST_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    lv_rst_req |-> rst_req_en); // R8
  AST_REQUEST_SETS_DET: assert property (@(posedge clk) disable iff (!rst_n)
    lv_rst_req |=> det_flag); // R3
  AST_DET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (det_flag && !det_ack && !reg_lowpwr) |=> det_flag); // R4
  AST_WARN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_flag && !warn_ack && !reg_lowpwr) |=> warn_flag); // R6
endmodule

bind lvd_flag_ctrl lvd_flag_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .det_ack    (det_ack),
  .warn_ack   (warn_ack),
  .rst_req_en (rst_req_en),
  .det_flag   (det_flag),
  .warn_flag  (warn_flag),
  .lv_rst_req (lv_rst_req),
  .reg_lowpwr (reg_lowpwr)
);

// File: tb/lvd_flag_ctrl_test.sv
`timescale 1ns/1ps
module lvd_flag_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] pwr_mode = 3'd1;
  logic       below_det_raw = 1'b0, below_warn_raw = 1'b0;
  logic       det_ack = 1'b0, warn_ack = 1'b0, rst_req_en = 1'b0;
  logic       det_flag, warn_flag, lv_rst_req, reg_lowpwr;
  int         errors = 0, checks = 0, cycles = 0;

  always #4 clk = ~clk;

  lvd_flag_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pwr_mode(pwr_mode),
    .below_det_raw(below_det_raw), .below_warn_raw(below_warn_raw),
    .det_ack(det_ack), .warn_ack(warn_ack), .rst_req_en(rst_req_en),
    .det_flag(det_flag), .warn_flag(warn_flag),
    .lv_rst_req(lv_rst_req), .reg_lowpwr(reg_lowpwr)
  );

  // mode[11:9] det[8] warn[7] ackd[6] ackw[5] en[4] | exp det[3] warn[2] req[1] lp[0]
  localparam int NVEC = 12;
  localparam logic [11:0] VEC [NVEC] = '{
    12'b001_11_00_1_1110,  // R3 R5 R8 both below, request on
    12'b001_00_00_1_1100,  // R3 R5 flags stay set without ack
    12'b001_00_10_1_0100,  // R4 detect ack accepted
    12'b000_01_01_0_0100,  // R6 warn ack refused, still below
    12'b010_00_01_0_0000,  // R6 warn ack accepted
    12'b011_10_00_0_1000,  // R8 enable off: no request
    12'b011_10_10_1_1010,  // R4 detect ack refused while below
    12'b100_11_00_1_0001,  // R7 R1 code 4 low power
    12'b101_11_00_1_0001,  // R7 R1 code 5 low power
    12'b110_11_00_1_1110,  // R1 unused code 6 is full performance
    12'b111_00_00_1_1100,  // R1 unused code 7 is full performance
    12'b001_00_11_1_0000   // R4 R6 both acks accepted
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    // R9: reset holds flags clear even with supply below
    below_det_raw = 1'b1; below_warn_raw = 1'b1; rst_req_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 det in reset", det_flag, 1'b0);
    check("R9 warn in reset", warn_flag, 1'b0);
    rst_n = 1'b1;
    // R2: two-flop synchroniser then flag register
    @(negedge clk);
    check("R2 det after 1 edge", det_flag, 1'b0);
    @(negedge clk);
    check("R2 det after 2 edges", det_flag, 1'b0);
    check("R2 req after 2 edges", lv_rst_req, 1'b1);
    @(negedge clk);
    check("R2 det after 3 edges", det_flag, 1'b1);
    check("R9 warn follows supply", warn_flag, 1'b1);

    for (int i = 0; i < NVEC; i++) begin
      pwr_mode       = VEC[i][11:9];
      below_det_raw  = VEC[i][8];
      below_warn_raw = VEC[i][7];
      rst_req_en     = VEC[i][4];
      det_ack = 1'b0; warn_ack = 1'b0;
      repeat (4) @(negedge clk);
      det_ack  = VEC[i][6];
      warn_ack = VEC[i][5];
      @(negedge clk);
      det_ack = 1'b0; warn_ack = 1'b0;
      @(negedge clk);
      check($sformatf("R3/R4 det vec%0d", i), det_flag, VEC[i][3]);
      check($sformatf("R5/R6 warn vec%0d", i), warn_flag, VEC[i][2]);
      check($sformatf("R8 req vec%0d", i), lv_rst_req, VEC[i][1]);
      check($sformatf("R1 lp vec%0d", i), reg_lowpwr, VEC[i][0]);
    end

    // R9: reset with supply healthy, flags stay clear after release
    below_det_raw = 1'b0; below_warn_raw = 1'b0; pwr_mode = 3'd1;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 det healthy", det_flag, 1'b0);
    check("R9 warn healthy", warn_flag, 1'b0);

    // R7: flags set, then low-power entry clears them within one edge
    below_det_raw = 1'b1; below_warn_raw = 1'b1;
    repeat (4) @(negedge clk);
    pwr_mode = 3'd4;
    @(negedge clk);
    check("R7 det cleared by lp", det_flag, 1'b0);
    check("R7 warn cleared by lp", warn_flag, 1'b0);
    check("R7 no req in lp", lv_rst_req, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule